// File: doc/BRIEF.md
# Key-Protected 64-bit Watchdog Timer

This block is a watchdog peripheral on a small 32-bit register bus. A 64-bit up-counter is built from two 32-bit halves. It is compared with a 64-bit period that is stored in two 32-bit registers. Software first sets up the counter, the period and the count controls. It then arms the watchdog by writing a two-step key sequence into the watchdog control word. While armed, software must repeat a two-step service sequence, which restarts the count from zero. If the count reaches the period first, the block latches a timeout flag and raises a reset request for one clock.

Once the first arming key is accepted, every configuration register is frozen and only the key field of the watchdog control word still has an effect. A key that does not fit the sequence drops the state machine back to its last stable state. When the block is armed, nothing clears the enable and the flag except the block's own reset.

Top module: `keyed_wdt`

## Requirements
- R1: A synchronous reset sets all registers to zero, drives reset request low and puts the key state machine in idle. The ID word at offset 0x00 always reads the parameter value, which defaults to 0x57440001, and writes to it are ignored.
- R2: While unlocked, the registers at 0x10 (count low), 0x14 (count high), 0x18 (period low) and 0x1C (period high) store full 32-bit writes. Timer control at 0x20 keeps only bits 7:6, and global control at 0x24 keeps only bits 3:0. Offset 0x04 reads zero. Read data is registered and appears one cycle after the read strobe.
- R3: The count rises by one on each clock only when all of these hold: global control bits 3:2 equal 2, bits 0 and 1 are both set, and timer control bits 7:6 are non-zero. A half whose release bit is clear is held at zero. The low half carries into the high half.
- R4: In idle, a write to offset 0x28 with key bits 31:16 = 0xA5C6 and bit 14 set enters pre-arm. In pre-arm, key 0xDA7E with bit 14 set enters armed. Bit 14 of 0x28 reads 1 from pre-arm onward. A first key written without bit 14 leaves the block idle.
- R5: From pre-arm onward, writes to offsets 0x10 through 0x24 are ignored, and so are all bits of 0x28 except the key field.
- R6: A key that does not fit the sequence returns the block to its last stable state. In pre-arm this means idle, which also unlocks the registers. In service this means armed, with no restart. In idle and armed such a key has no effect. A second key written without the first also has no effect.
- R7: While armed, key 0xA5C6 enters service. A following 0xDA7E returns the block to armed and clears the count to zero at that write's clock edge. Bit 14 is not required in either service write.
- R8: While armed or in service, when the count equals the period, the next edge sets bit 15 of 0x28 and drives reset request high for exactly one cycle. This is PERIOD+1 cycles after a restart. The flag and the enable stay set until reset, and no second request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after the read strobe |
| rst_req | output | 1 | One-cycle system reset request on timeout |

## Verification
A write takes effect at the clock edge where its strobe is sampled. Its read data is due one cycle after the read strobe, and it reflects the state just before that edge. The bench therefore drives inputs on the falling edge and samples one falling edge after each strobe. The counter first advances on the edge after the enable write, so back-to-back reads of a running count differ by exactly one, and the first read after enabling returns the loaded value. The reset request is timed against a bench cycle counter taken at the restart write. It must show up PERIOD+1 edges later and be high for exactly one sampled cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] OFS_ID     = 8'h00;
  localparam logic [7:0] OFS_EMU    = 8'h04;
  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PRD_LO = 8'h18;
  localparam logic [7:0] OFS_PRD_HI = 8'h1C;
  localparam logic [7:0] OFS_TCTL   = 8'h20;
  localparam logic [7:0] OFS_GCTL   = 8'h24;
  localparam logic [7:0] OFS_WCTL   = 8'h28;

  localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [15:0] KEY_SECOND = 16'hDA7E;

  localparam int WCTL_EN_BIT   = 14;
  localparam int WCTL_FLAG_BIT = 15;

  localparam logic [1:0] GMODE_WDOG = 2'd2;

  typedef enum logic [1:0] {
    WS_IDLE    = 2'd0,
    WS_PREARM  = 2'd1,
    WS_ARMED   = 2'd2,
    WS_SERVICE = 2'd3
  } wd_state_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              locked,
  output logic [DATA_W-1:0] prd_lo,
  output logic [DATA_W-1:0] prd_hi,
  output logic [1:0]        ena_mode,
  output logic [3:0]        gctl,
  output logic              ld_lo,
  output logic              ld_hi
);
  logic wr_open;

  always_comb begin
    wr_open = wr_en && !locked;
    ld_lo   = wr_open && (wr_addr == ADDR_W'(OFS_CNT_LO));
    ld_hi   = wr_open && (wr_addr == ADDR_W'(OFS_CNT_HI));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_lo   <= '0;
      prd_hi   <= '0;
      ena_mode <= '0;
      gctl     <= '0;
    end else if (wr_open) begin
      if (wr_addr == ADDR_W'(OFS_PRD_LO)) prd_lo   <= wr_data;
      if (wr_addr == ADDR_W'(OFS_PRD_HI)) prd_hi   <= wr_data;
      if (wr_addr == ADDR_W'(OFS_TCTL))   ena_mode <= wr_data[7:6];
      if (wr_addr == ADDR_W'(OFS_GCTL))   gctl     <= wr_data[3:0];
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int HALF_W = 32,
  parameter int NHALF  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic                    clr,
  input  logic [NHALF-1:0]        rel,
  input  logic [NHALF-1:0]        ld,
  input  logic [HALF_W-1:0]       ld_val,
  output logic [NHALF*HALF_W-1:0] count
);
  logic [NHALF-1:0] inc;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W-1:0] half_q;

    if (h == 0) begin : g_lsb
      assign inc[h] = adv;
    end else begin : g_upper
      assign inc[h] = adv && (&count[h*HALF_W-1:0]);
    end

    always_ff @(posedge clk) begin
      if (rst || clr || !rel[h])
        half_q <= '0;
      else if (ld[h])
        half_q <= ld_val;
      else if (inc[h])
        half_q <= half_q + 1'b1;
    end

    assign count[h*HALF_W +: HALF_W] = half_q;
  end
endmodule

// File: rtl/wdt_keyfsm.sv
module wdt_keyfsm
  import wdt_pkg::*;
#(
  parameter int KEY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [KEY_W-1:0] key,
  input  logic             en_bit,
  input  logic             hit,
  output logic             locked,
  output logic             armed,
  output logic             restart,
  output logic             flag,
  output logic             rst_req
);
  wd_state_t state_q, state_d;
  logic      is_first, is_second;

  always_comb begin
    is_first  = (key == KEY_W'(KEY_FIRST));
    is_second = (key == KEY_W'(KEY_SECOND));
    state_d   = state_q;
    restart   = 1'b0;
    case (state_q)
      WS_IDLE:
        if (ctl_wr && en_bit && is_first) state_d = WS_PREARM;
      WS_PREARM:
        if (ctl_wr) state_d = (en_bit && is_second) ? WS_ARMED : WS_IDLE;
      WS_ARMED:
        if (ctl_wr && is_first) state_d = WS_SERVICE;
      WS_SERVICE:
        if (ctl_wr) begin
          state_d = WS_ARMED;
          restart = is_second;
        end
      default: state_d = WS_IDLE;
    endcase
    locked = (state_q != WS_IDLE);
    armed  = (state_q == WS_ARMED) || (state_q == WS_SERVICE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WS_IDLE;
      flag    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_req <= 1'b0;
      if (armed && hit && !flag) begin
        flag    <= 1'b1;
        rst_req <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 32,
  parameter int          KEY_W  = 16,
  parameter logic [31:0] ID_VAL = 32'h5744_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam int NHALF = 2;
  localparam int CNT_W = NHALF * DATA_W;

  logic [DATA_W-1:0] prd_lo, prd_hi;
  logic [1:0]        ena_mode;
  logic [3:0]        gctl;
  logic              ld_lo, ld_hi;
  logic              locked, armed, restart, wd_flag;
  logic              ctl_wr, cnt_adv, cnt_hit;
  logic [CNT_W-1:0]  cnt_val;

  always_comb begin
    ctl_wr  = bus_we && (bus_addr == ADDR_W'(OFS_WCTL));
    cnt_adv = (gctl[3:2] == GMODE_WDOG) && (&gctl[1:0]) && (ena_mode != 2'd0);
    cnt_hit = (cnt_val == {prd_hi, prd_lo});
  end

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(bus_we), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .locked(locked), .prd_lo(prd_lo), .prd_hi(prd_hi), .ena_mode(ena_mode),
    .gctl(gctl), .ld_lo(ld_lo), .ld_hi(ld_hi)
  );

  wdt_counter #(.HALF_W(DATA_W), .NHALF(NHALF)) cnt_i (
    .clk(clk), .rst(rst), .adv(cnt_adv), .clr(restart), .rel(gctl[1:0]),
    .ld({ld_hi, ld_lo}), .ld_val(bus_wdata), .count(cnt_val)
  );

  wdt_keyfsm #(.KEY_W(KEY_W)) fsm_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr),
    .key(bus_wdata[DATA_W-1 -: KEY_W]), .en_bit(bus_wdata[WCTL_EN_BIT]),
    .hit(cnt_hit), .locked(locked), .armed(armed), .restart(restart),
    .flag(wd_flag), .rst_req(rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        ADDR_W'(OFS_ID):     bus_rdata <= DATA_W'(ID_VAL);
        ADDR_W'(OFS_CNT_LO): bus_rdata <= cnt_val[DATA_W-1:0];
        ADDR_W'(OFS_CNT_HI): bus_rdata <= cnt_val[CNT_W-1:DATA_W];
        ADDR_W'(OFS_PRD_LO): bus_rdata <= prd_lo;
        ADDR_W'(OFS_PRD_HI): bus_rdata <= prd_hi;
        ADDR_W'(OFS_TCTL):   bus_rdata <= DATA_W'({ena_mode, 6'b0});
        ADDR_W'(OFS_GCTL):   bus_rdata <= DATA_W'(gctl);
        ADDR_W'(OFS_WCTL):   bus_rdata <= DATA_W'({wd_flag, locked, 14'b0});
        default:             bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                rst_req,
  input logic                flag,
  input logic                locked,
  input logic                armed,
  input logic                restart,
  input logic                cnt_adv,
  input logic [1:0]          ld,
  input logic [2*DATA_W-1:0] count,
  input logic [DATA_W-1:0]   prd_lo,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr
);
  p_req_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  p_req_flag_r8: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> flag);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    flag |=> flag);

  p_no_req_unarmed_r8: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> armed);

  p_armed_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    armed |=> (armed && locked));

  p_lock_prd_r5: assert property (@(posedge clk) disable iff (rst)
    (locked && bus_we && bus_addr == ADDR_W'(OFS_PRD_LO)) |=> $stable(prd_lo));

  p_restart_zero_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (count == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_adv && !restart && ld == 2'b00 && count != '1) |=> (count == $past(count) + 1'b1));
endmodule

bind keyed_wdt keyed_wdt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .rst_req(rst_req), .flag(wd_flag), .locked(locked),
  .armed(armed), .restart(restart), .cnt_adv(cnt_adv), .ld({ld_hi, ld_lo}),
  .count(cnt_val), .prd_lo(prd_lo), .bus_we(bus_we), .bus_addr(bus_addr)
);

// File: tb/keyed_wdt_tb_top.sv
`timescale 1ns/1ps
module keyed_wdt_tb_top;
  localparam logic [7:0]  A_ID = 8'h00, A_EMU = 8'h04, A_CLO = 8'h10, A_CHI = 8'h14;
  localparam logic [7:0]  A_PLO = 8'h18, A_PHI = 8'h1C, A_TC = 8'h20, A_GC = 8'h24, A_WC = 8'h28;
  localparam logic [31:0] ID_EXP = 32'h5744_0001;
  localparam int          NTBL = 9;
  // {addr, write data, expected readback}
  localparam logic [71:0] TBL [NTBL] = '{
    {A_TC,  32'hFFFF_FFFF, 32'h0000_00C0},
    {A_GC,  32'hFFFF_FFFF, 32'h0000_000F},
    {A_CLO, 32'hAAAA_5555, 32'hAAAA_5555},
    {A_CHI, 32'h0000_1234, 32'h0000_1234},
    {A_PLO, 32'h1234_5678, 32'h1234_5678},
    {A_PHI, 32'h9ABC_DEF0, 32'h9ABC_DEF0},
    {A_ID,  32'h0000_0000, ID_EXP},
    {A_EMU, 32'hFFFF_FFFF, 32'h0000_0000},
    {A_WC,  32'h0000_C000, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0, errors = 0;
  int cyc = 0, pulses = 0, first_cyc = -1;

  always #10 clk = ~clk;

  keyed_wdt dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!rst && rst_req) begin
    pulses = pulses + 1;
    if (first_cyc < 0) first_cyc = cyc;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int c0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
    rd(A_ID, v);  chk("R1 id", v, ID_EXP);
    rd(A_CLO, v); chk("R1 cnt_lo", v, 0);
    rd(A_PHI, v); chk("R1 prd_hi", v, 0);
    rd(A_TC, v);  chk("R1 tctl", v, 0);
    rd(A_WC, v);  chk("R1 wctl", v, 0);

    // R2 table walk
    for (int i = 0; i < NTBL; i++) begin
      wr(TBL[i][71:64], TBL[i][63:32]);
      rd(TBL[i][71:64], v);
      chk("R2 table", v, TBL[i][31:0]);
    end

    // R3 gating and carry
    wr(A_GC, 32'h3); wr(A_TC, 32'h80); wr(A_CLO, 32'h0);
    rd(A_CLO, v); rd(A_CLO, v2);
    chk("R3 mode0 hold", v2, 0);
    wr(A_GC, 32'hA);
    rd(A_CLO, v); chk("R3 low half in reset", v, 0);
    wr(A_TC, 32'h0); wr(A_GC, 32'hB);
    wr(A_CLO, 32'hFFFF_FFFE); wr(A_CHI, 32'h5);
    rd(A_CLO, v); chk("R3 disabled hold", v, 32'hFFFF_FFFE);
    wr(A_TC, 32'h40);
    rd(A_CLO, v);  chk("R3 first after enable", v, 32'hFFFF_FFFE);
    rd(A_CLO, v);  chk("R3 step", v, 32'hFFFF_FFFF);
    rd(A_CHI, v);  chk("R3 carry", v, 32'h6);

    // R4 / R5 / R6 arming protocol
    wr(A_TC, 32'h0); wr(A_PLO, 32'h100); wr(A_PHI, 32'h0);
    wr(A_WC, 32'hA5C6_0000); rd(A_WC, v); chk("R4 no enable stays idle", v, 0);
    wr(A_WC, 32'hDA7E_4000); rd(A_WC, v); chk("R6 second key alone", v, 0);
    wr(A_WC, 32'hA5C6_4000); rd(A_WC, v); chk("R4 prearm enable", v, 32'h4000);
    wr(A_PLO, 32'h55); rd(A_PLO, v); chk("R5 locked in prearm", v, 32'h100);
    wr(A_WC, 32'h1111_4000); rd(A_WC, v); chk("R6 bad key to idle", v, 0);
    wr(A_PLO, 32'd200); rd(A_PLO, v); chk("R6 unlocked again", v, 32'd200);

    // R4, R5, R6, R7, R8 armed operation
    wr(A_CLO, 0); wr(A_CHI, 0); wr(A_GC, 32'hB); wr(A_TC, 32'h80);
    wr(A_WC, 32'hA5C6_4000); wr(A_WC, 32'hDA7E_4000);
    rd(A_WC, v); chk("R4 armed", v, 32'h4000);
    wr(A_TC, 32'h0); rd(A_TC, v); chk("R5 tctl locked", v, 32'h80);
    wr(A_GC, 32'h0); rd(A_GC, v); chk("R5 gctl locked", v, 32'hB);
    wr(A_WC, 32'h2222_0000); rd(A_WC, v); chk("R6 bad key armed", v, 32'h4000);
    wr(A_WC, 32'hA5C6_0000); wr(A_WC, 32'h3333_0000);
    rd(A_CLO, v); chk("R6 no restart", {31'b0, (v > 8 && v < 200)}, 32'h1);
    chk("R8 no early request", pulses, 0);
    wr(A_WC, 32'hA5C6_0000); wr(A_WC, 32'hDA7E_0000);
    c0 = cyc;
    rd(A_CLO, v); chk("R7 restart", v, 0);
    for (int k = 0; k < 400 && first_cyc < 0; k++) @(negedge clk);
    chk("R8 timeout latency", first_cyc - c0, 201);
    repeat (20) @(negedge clk);
    chk("R8 single pulse", pulses, 1);
    rd(A_WC, v); chk("R8 flag and enable", v, 32'hC000);

    // R1 reset clears and unlocks
    do_reset();
    chk("R1 rst_req after reset", {31'b0, rst_req}, 0);
    rd(A_WC, v);  chk("R1 wctl after reset", v, 0);
    rd(A_GC, v);  chk("R1 gctl after reset", v, 0);
    wr(A_PLO, 32'h7); rd(A_PLO, v); chk("R1 unlocked after reset", v, 32'h7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule